// File: doc/BRIEF.md
# CAN Controller Stop-Mode Sequencer

This block controls low-power entry and exit for a CAN protocol engine. A control-register bit asks for the module to be disabled. The sequencer then waits for a point where the bus can safely be left. That point is either an idle bus or a recessive bit sampled in the third slot of the intermission field. After that it waits for the engine's internal work to drain. It then drops the engine clock enable, holds the transmit line recessive, masks the receive path seen by the engine, and raises the stop-acknowledge and not-ready flags. The sequencer itself stays clocked, so the register side remains usable.

If the engine is halted when the request arrives, the sequencer first leaves halt. It resynchronizes on eleven consecutive recessive bits and only then looks for the safe point. A bus-off recovery count is kept here. It is frozen while stopped and continues from the same value afterwards. Stop is left by a hard reset, by the soft-reset bit, or by clearing the disable bit. After a disable-bit exit the block resynchronizes before it clears its flags. The first dominant bit seen during that resynchronization is flagged as a start-of-frame, to be received without arbitration. Bit framing, arbitration, error counting and interrupts live elsewhere. Here they appear only as plain inputs.

Top module: `can_stop_seq`

## Requirements
- R1: With the disable bit set and initialization done, stop proceeds past the bus wait only when `bus_idle_i` is high, or when a bit strobe with `ifs3_i` high samples `rx_i` = 1. A dominant third intermission bit does not qualify.
- R2: After the bus condition, `eng_clk_en_o` stays high while `eng_busy_i` is high. It drops on the edge after busy is seen low.
- R3: While stopped, `eng_clk_en_o` is 0. In every other state it is 1.
- R4: While stopped, `tx_o` is 1 and `rx_eng_o` is 1 whatever `eng_tx_i` and `rx_i` are. Otherwise they pass `eng_tx_i` and `rx_i` through.
- R5: `stop_ack_o` and `not_ready_o` both become 1 on the edge that enters stop. After a disable-bit exit they return to 0 on the edge that samples the 11th consecutive recessive bit.
- R6: Stop is left by clearing `mod_disable_i`, which starts resynchronization. It is also left by `soft_rst_i` or `rst`; either returns the block to run with both flags 0 and the bus-off count 0 on the next edge.
- R7: If `halt_i` is high when the request is accepted, `halt_exit_o` is 1 and the clock stays enabled until 11 consecutive recessive bits are seen. Only then is the R1 bus condition evaluated.
- R8: `boff_cnt_o` counts recessive bit strobes while `bus_off_i` is high and clears while it is low. While stopped it holds its value, and it resumes from that value after exit.
- R9: During resynchronization after a disable-bit exit, `sof_rx_o` is 1 during the first dominant bit strobe only.
- R10: A disable request made while `init_done_i` is 0 is held and has no effect until `init_done_i` rises.
- R11: A dominant bit during resynchronization restarts the count of 11 recessive bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (register side, never gated) |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst_i | input | 1 | Soft-reset control bit |
| mod_disable_i | input | 1 | Module-disable control bit |
| init_done_i | input | 1 | Basic initialization finished |
| halt_i | input | 1 | Engine is in halt |
| bus_idle_i | input | 1 | Bus idle indication |
| ifs3_i | input | 1 | Current bit is the third intermission bit |
| bit_tick_i | input | 1 | One-cycle strobe at each bit sample point |
| rx_i | input | 1 | Sampled bus level (1 = recessive) |
| eng_busy_i | input | 1 | Engine internal activity pending |
| bus_off_i | input | 1 | Engine is bus-off |
| eng_tx_i | input | 1 | Engine transmit level |
| eng_clk_en_o | output | 1 | Engine clock enable |
| tx_o | output | 1 | Transmit line |
| rx_eng_o | output | 1 | Receive level delivered to engine |
| stop_ack_o | output | 1 | Stop acknowledged flag |
| not_ready_o | output | 1 | Not-ready flag |
| halt_exit_o | output | 1 | Halt being left, resynchronizing |
| sof_rx_o | output | 1 | Dominant bit to be taken as start-of-frame, no arbitration |
| boff_cnt_o | output | 8 | Bus-off recovery count |

## Verification
Stop entry is driven in four ways: through an idle bus, through a recessive third intermission bit, through a dominant one, and with the engine still busy. These show that only the two qualifying bus conditions start the drain wait, and that busy holds the clock on. Exit is driven by clearing the disable bit, by soft reset and by hard reset. A resynchronization broken by a dominant bit tells a consecutive-bit count apart from a cumulative one, and it shows that only the first dominant bit is marked as start-of-frame. Bus-off strobes sent before, during and after stop show that the count freezes rather than clears, and a halted request shows that resynchronization comes before the bus wait.

// File: rtl/can_stop_pkg.sv
package can_stop_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT_BUS,
        ST_WAIT_DRAIN,
        ST_STOPPED,
        ST_RESYNC
    } stop_state_e;

    typedef struct packed {
        logic idle;
        logic ifs3;
        logic tick;
        logic rx;
    } bus_view_t;

    localparam int unsigned RESYNC_BITS = 11;

    // Safe point for leaving the bus: idle, or recessive third intermission bit
    function automatic logic bus_safe(input bus_view_t b);
        return b.idle | (b.ifs3 & b.tick & b.rx);
    endfunction

endpackage

// File: rtl/can_recessive_run.sv
module can_recessive_run #(
    parameter int unsigned RUN_LEN = 11
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic tick,
    input  logic rx,
    output logic done
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    assign done = en & tick & rx & (run_q == LAST);

    always_ff @(posedge clk) begin
        if (clr || !en) begin
            run_q <= '0;
        end else if (tick) begin
            if (!rx || done) run_q <= '0;
            else             run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/can_boff_counter.sv
module can_boff_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         freeze,
    input  logic         bus_off,
    input  logic         tick,
    input  logic         rx,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (clr) begin
            count <= '0;
        end else if (!freeze) begin
            if (!bus_off)                          count <= '0;
            else if (tick && rx && count != MAXV)  count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/can_stop_fsm.sv
module can_stop_fsm
    import can_stop_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        disable_req,
    input  logic        init_done,
    input  logic        halt,
    input  logic        safe,
    input  logic        busy,
    input  logic        resync_done,
    input  logic        dom_bit,
    output stop_state_e state,
    output logic        pre_stop,
    output logic        sof_pend,
    output logic        ack
);
    stop_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:
                if (disable_req && init_done) nxt = halt ? ST_RESYNC : ST_WAIT_BUS;
            ST_WAIT_BUS:
                if (!disable_req) nxt = ST_RUN;
                else if (safe)    nxt = ST_WAIT_DRAIN;
            ST_WAIT_DRAIN:
                if (!disable_req) nxt = ST_RUN;
                else if (!busy)   nxt = ST_STOPPED;
            ST_STOPPED:
                if (!disable_req) nxt = ST_RESYNC;
            ST_RESYNC:
                if (pre_stop && !disable_req) nxt = ST_RUN;
                else if (resync_done)         nxt = pre_stop ? ST_WAIT_BUS : ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state    <= ST_RUN;
            pre_stop <= 1'b0;
            sof_pend <= 1'b0;
            ack      <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && nxt == ST_RESYNC)     pre_stop <= 1'b1;
            else if (state == ST_STOPPED)                pre_stop <= 1'b0;
            else if (nxt != ST_RESYNC)                   pre_stop <= 1'b0;

            if (state == ST_STOPPED && nxt == ST_RESYNC) sof_pend <= 1'b1;
            else if (state == ST_RESYNC && dom_bit)      sof_pend <= 1'b0;
            else if (nxt != ST_RESYNC)                   sof_pend <= 1'b0;

            if (nxt == ST_STOPPED)                       ack <= 1'b1;
            else if (state == ST_RESYNC && !pre_stop && resync_done) ack <= 1'b0;
        end
    end
endmodule

// File: rtl/can_stop_seq.sv
module can_stop_seq
    import can_stop_pkg::*;
#(
    parameter int unsigned BOFF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic              mod_disable_i,
    input  logic              init_done_i,
    input  logic              halt_i,
    input  logic              bus_idle_i,
    input  logic              ifs3_i,
    input  logic              bit_tick_i,
    input  logic              rx_i,
    input  logic              eng_busy_i,
    input  logic              bus_off_i,
    input  logic              eng_tx_i,
    output logic              eng_clk_en_o,
    output logic              tx_o,
    output logic              rx_eng_o,
    output logic              stop_ack_o,
    output logic              not_ready_o,
    output logic              halt_exit_o,
    output logic              sof_rx_o,
    output logic [BOFF_W-1:0] boff_cnt_o
);
    stop_state_e state;
    bus_view_t   bus;
    logic        clr, pre_stop, sof_pend, ack, resync_done, in_resync, stopped;

    assign clr       = rst | soft_rst_i;
    assign bus       = '{idle: bus_idle_i, ifs3: ifs3_i, tick: bit_tick_i, rx: rx_i};
    assign in_resync = (state == ST_RESYNC);
    assign stopped   = (state == ST_STOPPED);

    can_stop_fsm u_fsm (
        .clk         (clk),
        .clr         (clr),
        .disable_req (mod_disable_i),
        .init_done   (init_done_i),
        .halt        (halt_i),
        .safe        (bus_safe(bus)),
        .busy        (eng_busy_i),
        .resync_done (resync_done),
        .dom_bit     (bit_tick_i & ~rx_i),
        .state       (state),
        .pre_stop    (pre_stop),
        .sof_pend    (sof_pend),
        .ack         (ack)
    );

    can_recessive_run #(.RUN_LEN(RESYNC_BITS)) u_run (
        .clk  (clk),
        .clr  (clr),
        .en   (in_resync),
        .tick (bit_tick_i),
        .rx   (rx_i),
        .done (resync_done)
    );

    can_boff_counter #(.W(BOFF_W)) u_boff (
        .clk     (clk),
        .clr     (clr),
        .freeze  (stopped),
        .bus_off (bus_off_i),
        .tick    (bit_tick_i),
        .rx      (rx_i),
        .count   (boff_cnt_o)
    );

    assign eng_clk_en_o = ~stopped;
    assign tx_o         = stopped ? 1'b1 : eng_tx_i;
    assign rx_eng_o     = stopped ? 1'b1 : rx_i;
    assign stop_ack_o   = ack;
    assign not_ready_o  = ack;
    assign halt_exit_o  = in_resync & pre_stop;
    assign sof_rx_o     = in_resync & ~pre_stop & sof_pend & bit_tick_i & ~rx_i;
endmodule

// File: rtl/can_stop_seq_chk.sv
module can_stop_seq_chk #(
    parameter int unsigned BOFF_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst_i,
    input logic              mod_disable_i,
    input logic              init_done_i,
    input logic              eng_busy_i,
    input logic              eng_clk_en_o,
    input logic              tx_o,
    input logic              rx_eng_o,
    input logic              stop_ack_o,
    input logic              not_ready_o,
    input logic              halt_exit_o,
    input logic [BOFF_W-1:0] boff_cnt_o
);
    // R4
    line_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_clk_en_o |-> (tx_o && rx_eng_o));

    // R5
    flags_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_clk_en_o |-> (stop_ack_o && not_ready_o));

    // R2
    gate_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(eng_clk_en_o) |-> ($past(mod_disable_i) && !$past(eng_busy_i) && $past(init_done_i)));

    // R8
    boff_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!eng_clk_en_o && $past(!eng_clk_en_o)) |-> $stable(boff_cnt_o));

    // R6
    soft_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst_i) |-> (eng_clk_en_o && !stop_ack_o && boff_cnt_o == '0));

    // R7
    halt_clock_on_chk: assert property (@(posedge clk) disable iff (rst)
        halt_exit_o |-> eng_clk_en_o);
endmodule

bind can_stop_seq can_stop_seq_chk #(.BOFF_W(BOFF_W)) u_chk (.*);

// File: tb/tb_can_stop_seq.sv
module tb_can_stop_seq;
    logic clk = 0, rst = 1, soft_rst = 0, dis = 0, init_done = 0, halt = 0;
    logic idle = 0, ifs3 = 0, tick = 0, rx = 1, busy = 0, boff_in = 0, etx = 1;
    logic clk_en, tx, rxe, ack, nr, hx, sof;
    logic [7:0] bcnt;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    can_stop_seq dut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .mod_disable_i(dis),
        .init_done_i(init_done), .halt_i(halt), .bus_idle_i(idle), .ifs3_i(ifs3),
        .bit_tick_i(tick), .rx_i(rx), .eng_busy_i(busy), .bus_off_i(boff_in),
        .eng_tx_i(etx), .eng_clk_en_o(clk_en), .tx_o(tx), .rx_eng_o(rxe),
        .stop_ack_o(ack), .not_ready_o(nr), .halt_exit_o(hx), .sof_rx_o(sof),
        .boff_cnt_o(bcnt));

    // Behavioural reference: phase 0 run,1 bus wait,2 drain,3 stopped,4 resync
    int m_phase = 0, m_run = 0, m_boff = 0;
    bit m_halted = 0, m_first = 0, m_flag = 0;

    always @(posedge clk) begin
        int p;
        bit fin;
        if (rst || soft_rst) begin
            m_phase = 0; m_run = 0; m_boff = 0; m_halted = 0; m_first = 0; m_flag = 0;
        end else begin
            p = m_phase;
            fin = (p == 4) && tick && rx && (m_run == 10);
            if (p != 3) begin
                if (!boff_in) m_boff = 0;
                else if (tick && rx && m_boff < 255) m_boff++;
            end
            if (p == 4 && tick) m_run = (rx && !fin) ? m_run + 1 : 0;
            if (p == 4 && tick && !rx) m_first = 0;
            case (p)
                0: if (dis && init_done) begin
                       if (halt) begin m_phase = 4; m_halted = 1; end
                       else m_phase = 1;
                   end
                1: if (!dis) m_phase = 0;
                   else if (idle || (ifs3 && tick && rx)) m_phase = 2;
                2: if (!dis) m_phase = 0;
                   else if (!busy) begin m_phase = 3; m_flag = 1; end
                3: if (!dis) begin m_phase = 4; m_first = 1; m_halted = 0; end
                4: if (m_halted && !dis) m_phase = 0;
                   else if (fin) begin
                       if (!m_halted) m_flag = 0;
                       m_phase = m_halted ? 1 : 0;
                   end
                default: m_phase = 0;
            endcase
            if (m_phase != 4) begin m_run = 0; m_halted = (m_phase == 4) && m_halted; m_first = 0; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst && !finished) begin
            chk("R3", "clk_en", clk_en, m_phase != 3);
            chk("R4", "tx", tx, (m_phase == 3) ? 1 : etx);
            chk("R4", "rx_eng", rxe, (m_phase == 3) ? 1 : rx);
            chk("R5", "stop_ack", ack, m_flag);
            chk("R5", "not_ready", nr, m_flag);
            chk("R7", "halt_exit", hx, (m_phase == 4) && m_halted);
            chk("R9", "sof", sof, (m_phase == 4) && !m_halted && m_first && tick && !rx);
            chk("R8", "boff", bcnt, m_boff);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic send_bit(input logic v, input logic third = 0);
        tick = 1; rx = v; ifs3 = third;
        step();
        tick = 0; ifs3 = 0; rx = 1;
        step();
    endtask

    task automatic recessive(input int n);
        for (int i = 0; i < n; i++) send_bit(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst = 0;
        step();
        // R6: reset state
        chk("R6", "reset clk_en", clk_en, 1);
        chk("R6", "reset ack", ack, 0);
        chk("R6", "reset boff", bcnt, 0);

        // R10: request before init is held
        dis = 1; idle = 1;
        step(6);
        chk("R10", "held before init", clk_en, 1);
        init_done = 1;
        step(4);
        chk("R10", "proceeds after init", clk_en, 0);
        chk("R5", "ack on entry", ack, 1);

        // R4: lines forced while stopped
        etx = 0; rx = 0; step();
        chk("R4", "tx forced", tx, 1);
        chk("R4", "rx masked", rxe, 1);
        etx = 1; rx = 1;

        // R6, R9, R11: exit by clearing disable, broken resync
        dis = 0; idle = 0;
        step();
        chk("R6", "exit clk on", clk_en, 1);
        recessive(6);
        tick = 1; rx = 0; #5;
        chk("R9", "first dominant sof", sof, 1);
        step(); tick = 0; rx = 1; step();
        send_bit(0);
        recessive(10);
        chk("R11", "count restarted", ack, 1);
        recessive(1);
        chk("R5", "flags cleared", ack, 0);

        // R1: dominant third intermission bit does not qualify
        dis = 1; idle = 0;
        step(2);
        send_bit(0, 1);
        step(3);
        chk("R1", "dominant ifs3", clk_en, 1);
        // R2: busy holds clock on
        busy = 1;
        send_bit(1, 1);
        step(4);
        chk("R2", "busy holds", clk_en, 1);
        busy = 0;
        step(2);
        chk("R1", "recessive ifs3 stop", clk_en, 0);

        // R6: soft reset exit
        soft_rst = 1; step(); soft_rst = 0; dis = 0;
        step();
        chk("R6", "soft exit", clk_en, 1);
        chk("R6", "soft ack", ack, 0);

        // R8: bus-off freeze
        boff_in = 1;
        recessive(5);
        chk("R8", "boff counted", bcnt, 5);
        dis = 1; idle = 1; step(3); idle = 0;
        recessive(4);
        chk("R8", "boff frozen", bcnt, 5);
        dis = 0; step();
        recessive(11);
        chk("R8", "boff resumed", bcnt, 16);
        boff_in = 0; step(2);

        // R7: halt pending
        halt = 1; dis = 1; idle = 1;
        step(2);
        halt = 0;
        chk("R7", "halt exit shown", hx, 1);
        step(4);
        chk("R7", "no stop before resync", clk_en, 1);
        recessive(11);
        step(3);
        chk("R7", "stop after resync", clk_en, 0);

        // R6: hard reset exit
        rst = 1; step(); rst = 0; dis = 0; idle = 0;
        step();
        chk("R6", "hard exit", clk_en, 1);
        chk("R6", "hard ack", ack, 0);

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            dis = ($urandom_range(0, 9) < 7);
            idle = ($urandom_range(0, 5) == 0);
            busy = $urandom_range(0, 1);
            boff_in = ($urandom_range(0, 7) != 0);
            halt = ($urandom_range(0, 9) == 0);
            etx = $urandom_range(0, 1);
            send_bit($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0);
        end
        step(2);
        finish_run();
    end
endmodule